// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block controls one port of eight general-purpose pins. A small register interface holds an output data byte, three drive-mode bit planes and a global-select byte. Together the three bit planes give each pin a 3-bit drive mode. For every pin, combinational drive logic turns that mode and the pin's output bit into five driver enables: strong high, resistive high, strong low, resistive low and slow slew. The pad drivers outside the block act on these enables.

When a pin's global-select bit is set, the pin's output bit comes from the global output bus and no longer from the data register. Each pin's input level passes through a two-flop synchronizer. A read of the data address returns these synchronized levels. A selected high-impedance pin also sends its level onto the global input bus. In the analog high-impedance mode the digital input is gated off, so the pin reads as 0.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the data register is 0 and the global-select register is 0. Every pin is in mode 010: plane DM0 = 0x00, DM1 = 0xFF, DM2 = 0x00. No driver enable is asserted.
- R2: A write happens at a rising clock edge while `wr_en` is high. The addresses are 0 = data, 1 = DM0 plane, 2 = DM1 plane, 3 = DM2 plane and 4 = global select. Addresses 1 to 4 read back the stored byte.
- R3: A pin's mode is {DM2,DM1,DM0}. The enables for output bit 0 / output bit 1 are as follows. Mode 000: resistive low / strong high. Mode 001: strong low / strong high. Mode 010: none / none. Mode 011: strong low / resistive high. Mode 100: none / strong high. Mode 101: strong low / strong high. Mode 110: none / none. Mode 111: strong low / none.
- R4: A pin with its global-select bit at 1 takes its output bit from `glb_out`. A pin with the bit at 0 takes it from the data register.
- R5: A read of address 0 returns the pin input levels delayed by two rising clock edges, not the data register contents.
- R6: A pin in mode 110 reads as 0 at address 0 and drives 0 onto `glb_in`, whatever its input level.
- R7: `glb_in` for a pin carries its synchronized level only when its global-select bit is 1 and its mode is 010. Otherwise that bit of `glb_in` is 0.
- R8: `drv_slow` is asserted exactly when a strong driver is enabled in mode 100, 101 or 111.
- R9: No pin ever has a high-side enable and a low-side enable asserted together.
- R10: Addresses 5 to 7 read as 0, and a write to them changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| pin_in | input | 8 | Pin input levels |
| glb_out | input | 8 | Global output bus, one bit per pin |
| glb_in | output | 8 | Global input bus, one bit per pin |
| drv_strong_hi | output | 8 | Strong pull-up enable per pin |
| drv_res_hi | output | 8 | Resistive pull-up enable per pin |
| drv_strong_lo | output | 8 | Strong pull-down enable per pin |
| drv_res_lo | output | 8 | Resistive pull-down enable per pin |
| drv_slow | output | 8 | Slow-slew enable per pin |

## Verification
The driver enables are combinational from the stored planes. A wrong plane bit therefore shows up on the enables in the same cycle as the next output-bit pattern that exposes it, and the plane readback shows it on the next read. A fault in the synchronizer shows up as a read or a `glb_in` value that arrives one edge early or late, or one that ignores the analog gating. Random mixes of writes, pin levels and bus values are checked against a bench model after every step, so such a fault is caught within a few steps.

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
  parameter int NPINS = 8,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] rdata,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] glb_out,
  output logic [NPINS-1:0] glb_in,
  output logic [NPINS-1:0] drv_strong_hi,
  output logic [NPINS-1:0] drv_res_hi,
  output logic [NPINS-1:0] drv_strong_lo,
  output logic [NPINS-1:0] drv_res_lo,
  output logic [NPINS-1:0] drv_slow
);
  localparam logic [AW-1:0] A_DATA = AW'(0);
  localparam logic [AW-1:0] A_DM0  = AW'(1);
  localparam logic [AW-1:0] A_DM1  = AW'(2);
  localparam logic [AW-1:0] A_DM2  = AW'(3);
  localparam logic [AW-1:0] A_GSEL = AW'(4);

  logic [NPINS-1:0] data_q, dm0_q, dm1_q, dm2_q, gsel_q;
  logic [NPINS-1:0] sync1_q, sync2_q;
  logic [NPINS-1:0] analog, hiz_dig, pin_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      dm0_q  <= '0;
      dm1_q  <= '1;
      dm2_q  <= '0;
      gsel_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_DATA: data_q <= wdata;
        A_DM0:  dm0_q  <= wdata;
        A_DM1:  dm1_q  <= wdata;
        A_DM2:  dm2_q  <= wdata;
        A_GSEL: gsel_q <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic [2:0] mode;
    logic       bit_out;
    logic [4:0] en;
    assign mode    = {dm2_q[i], dm1_q[i], dm0_q[i]};
    assign bit_out = gsel_q[i] ? glb_out[i] : data_q[i];

    always_comb begin
      case (mode)
        3'b000:  en = bit_out ? 5'b10000 : 5'b00010;
        3'b001:  en = bit_out ? 5'b10000 : 5'b00100;
        3'b011:  en = bit_out ? 5'b01000 : 5'b00100;
        3'b100:  en = bit_out ? 5'b10001 : 5'b00000;
        3'b101:  en = bit_out ? 5'b10001 : 5'b00101;
        3'b111:  en = bit_out ? 5'b00000 : 5'b00101;
        default: en = 5'b00000;
      endcase
    end

    assign drv_strong_hi[i] = en[4];
    assign drv_res_hi[i]    = en[3];
    assign drv_strong_lo[i] = en[2];
    assign drv_res_lo[i]    = en[1];
    assign drv_slow[i]      = en[0];
    assign analog[i]        = (mode == 3'b110);
    assign hiz_dig[i]       = (mode == 3'b010);
  end

  assign pin_rd = sync2_q & ~analog;
  assign glb_in = pin_rd & gsel_q & hiz_dig;

  always_comb begin
    case (addr)
      A_DATA:  rdata = pin_rd;
      A_DM0:   rdata = dm0_q;
      A_DM1:   rdata = dm1_q;
      A_DM2:   rdata = dm2_q;
      A_GSEL:  rdata = gsel_q;
      default: rdata = '0;
    endcase
  end

  p_no_contention_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((drv_strong_hi | drv_res_hi) & (drv_strong_lo | drv_res_lo)) == '0);

  p_slow_needs_strong_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_slow & ~(drv_strong_hi | drv_strong_lo)) == '0);

  p_analog_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_DATA) |-> ((rdata & analog) == '0));

  p_gsel_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_GSEL) |=> (gsel_q == $past(wdata)));

  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (gsel_q == '0 && dm1_q == '1 && dm0_q == '0 && dm2_q == '0
                       && drv_strong_hi == '0 && drv_strong_lo == '0));

  p_sync_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (sync1_q == $past(pin_in)));
endmodule

// File: tb/tb_gpio_port_ctrl.sv
module tb_gpio_port_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       wr_en = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, pin_in = 0, glb_out = 0;
  logic [7:0] rdata, glb_in, shi, rhi, slo, rlo, slow;

  int checks = 0, errs = 0;

  logic [7:0] m_data, m_dm0, m_dm1, m_dm2, m_gsel, m_s1, m_s2;

  gpio_port_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .glb_out(glb_out), .glb_in(glb_in),
    .drv_strong_hi(shi), .drv_res_hi(rhi), .drv_strong_lo(slo),
    .drv_res_lo(rlo), .drv_slow(slow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [4:0] exp_drv(input logic [2:0] m, input logic d);
    case (m)
      3'd0: return d ? 5'b10000 : 5'b00010;
      3'd1: return d ? 5'b10000 : 5'b00100;
      3'd3: return d ? 5'b01000 : 5'b00100;
      3'd4: return d ? 5'b10001 : 5'b00000;
      3'd5: return d ? 5'b10001 : 5'b00101;
      3'd7: return d ? 5'b00000 : 5'b00101;
      default: return 5'b00000;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [7:0] e_shi, e_rhi, e_slo, e_rlo, e_slow, ana, dig, rd;
    for (int i = 0; i < 8; i++) begin
      logic [2:0] m;
      logic d;
      logic [4:0] e;
      m = {m_dm2[i], m_dm1[i], m_dm0[i]};
      d = m_gsel[i] ? glb_out[i] : m_data[i];
      e = exp_drv(m, d);
      {e_shi[i], e_rhi[i], e_slo[i], e_rlo[i], e_slow[i]} = e;
      ana[i] = (m == 3'b110);
      dig[i] = (m == 3'b010);
    end
    rd = m_s2 & ~ana;
    chk({tag, " R3/R4 strong_hi"}, shi, e_shi);
    chk({tag, " R3/R4 res_hi"}, rhi, e_rhi);
    chk({tag, " R3/R4 strong_lo"}, slo, e_slo);
    chk({tag, " R3/R4 res_lo"}, rlo, e_rlo);
    chk({tag, " R8 slow"}, slow, e_slow);
    chk({tag, " R9 no contention"}, (shi | rhi) & (slo | rlo), 8'h00);
    chk({tag, " R6/R7 glb_in"}, glb_in, rd & m_gsel & dig);
    case (addr)
      3'd0: chk({tag, " R5/R6 read pins"}, rdata, rd);
      3'd1: chk({tag, " R2 read dm0"}, rdata, m_dm0);
      3'd2: chk({tag, " R2 read dm1"}, rdata, m_dm1);
      3'd3: chk({tag, " R2 read dm2"}, rdata, m_dm2);
      3'd4: chk({tag, " R2 read gsel"}, rdata, m_gsel);
      default: chk({tag, " R10 unmapped read"}, rdata, 8'h00);
    endcase
  endtask

  task automatic step(input logic we, input logic [2:0] a, input logic [7:0] wd,
                      input logic [7:0] pin, input logic [7:0] go, input string tag);
    @(negedge clk);
    wr_en = we; addr = a; wdata = wd; pin_in = pin; glb_out = go;
    #1;
    check_all(tag);
    @(posedge clk);
    if (we) begin
      case (a)
        3'd0: m_data = wd;
        3'd1: m_dm0 = wd;
        3'd2: m_dm1 = wd;
        3'd3: m_dm2 = wd;
        3'd4: m_gsel = wd;
        default: ;
      endcase
    end
    m_s2 = m_s1;
    m_s1 = pin;
  endtask

  task automatic set_mode(input logic [2:0] m);
    step(1, 3'd1, {8{m[0]}}, pin_in, glb_out, "setm");
    step(1, 3'd2, {8{m[1]}}, pin_in, glb_out, "setm");
    step(1, 3'd3, {8{m[2]}}, pin_in, glb_out, "setm");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_data = 0; m_dm0 = 0; m_dm1 = 8'hFF; m_dm2 = 0; m_gsel = 0; m_s1 = 0; m_s2 = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1 reset state
    for (int a = 0; a < 5; a++) step(0, 3'(a), 8'h00, 8'h00, 8'hFF, "R1 reset");

    // R3 mode sweep with both data levels, bypass off
    for (int m = 0; m < 8; m++) begin
      set_mode(3'(m));
      step(1, 3'd0, 8'h5A, 8'h00, 8'h00, "R3 sweep");
      step(0, 3'd2, 8'h00, 8'h00, 8'h00, "R3 sweep");
      step(1, 3'd0, 8'hA5, 8'h00, 8'hFF, "R3 sweep");
      step(0, 3'd3, 8'h00, 8'h00, 8'hFF, "R3 sweep");
    end

    // R4 bypass: global bus drives selected pins in strong mode
    set_mode(3'd1);
    step(1, 3'd0, 8'h00, 8'h00, 8'h00, "R4");
    step(1, 3'd4, 8'h0F, 8'h00, 8'hFF, "R4");
    step(0, 3'd4, 8'h00, 8'h00, 8'h3C, "R4 bypass");

    // R5 two-edge latency, data register not returned
    step(1, 3'd0, 8'hFF, 8'hC3, 8'h00, "R5");
    step(0, 3'd0, 8'h00, 8'h00, 8'h00, "R5 one edge");
    step(0, 3'd0, 8'h00, 8'h00, 8'h00, "R5 two edges");
    step(0, 3'd0, 8'h00, 8'h00, 8'h00, "R5 settled");

    // R7 global input in mode 010; R6 analog mode gated
    set_mode(3'd2);
    step(1, 3'd4, 8'hFF, 8'hA5, 8'h00, "R7");
    step(0, 3'd0, 8'h00, 8'hA5, 8'h00, "R7");
    step(0, 3'd0, 8'h00, 8'hA5, 8'h00, "R7 glb_in");
    set_mode(3'd6);
    step(0, 3'd0, 8'h00, 8'hFF, 8'h00, "R6");
    step(0, 3'd0, 8'h00, 8'hFF, 8'h00, "R6 analog");
    step(0, 3'd0, 8'h00, 8'hFF, 8'h00, "R6 analog");

    // R10 unmapped writes ignored
    step(1, 3'd5, 8'h11, 8'h00, 8'h00, "R10");
    step(1, 3'd6, 8'h22, 8'h00, 8'h00, "R10");
    step(1, 3'd7, 8'h33, 8'h00, 8'h00, "R10");
    for (int a = 0; a < 8; a++) step(0, 3'(a), 8'h00, 8'h00, 8'h00, "R10 after");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      step(1'($urandom), 3'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), "rand");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end
endmodule